// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a serial-bus slave that answers to one fixed 7-bit address and gives a bus master byte-wide access to a register file of 24 locations. It does not hold the registers. It drives an address, a write strobe with data and a read strobe toward the register file. It takes back the read data combinationally for the address it presents. An internal pointer picks the location. The master loads the pointer with the first byte of a write transaction. The pointer advances after every data byte written and after every byte read that the master acknowledges.

The bus lines are sampled with the system clock. Each line passes through a synchronizer and a glitch filter before START, STOP and clock edges are decoded. SDA is open-drain: the block has an output enable, and the bus is driven low while that enable is high. Every STOP puts the pointer back at location 0, so a master can poll that location with bare read transactions. A repeated START keeps the pointer.

A reset of the register file to its defaults can be requested in two ways. One is a general-call command. The other is a reserved pointer value. In both cases a reset-request output stays high for a fixed number of clocks. During that window the slave ignores the bus and never drives SDA.

Top module: `i2c_regport`

## Requirements
- R1: After a START, the byte 0x90 (write) or 0x91 (read) is acknowledged by `sda_oe` high during the ninth SCL pulse. Any other address byte except 0x00 gets no acknowledge. Bytes travel MSB first.
- R2: In a write, the first byte after the address loads the pointer and is acknowledged. Each further byte is acknowledged and presented on `reg_wr_data` with a one-cycle `reg_wr_en` at `reg_addr` equal to the pointer. The pointer then advances by one.
- R3: In a read, the byte at the pointer is shifted out MSB first. A master ACK advances the pointer and sends the next location. A master NACK ends the transfer with the pointer unchanged.
- R4: Any STOP returns the slave to idle and sets the pointer to 0x00.
- R5: Data bytes aimed at locations outside the writable window 0x09..0x12 are still acknowledged, but no write strobe is issued.
- R6: A repeated START behaves like a START and keeps the pointer, so a pointer load followed by a repeated START and a read returns data from the loaded location.
- R7: The general-call address 0x00 with the write bit is acknowledged. A following command byte 0x06 is acknowledged and starts a reset. Any other command byte is not acknowledged.
- R8: A pointer byte of 0xBF is not acknowledged and starts a reset.
- R9: A reset holds `rst_req` high for exactly RST_CLKS clocks. Meanwhile `sda_oe` stays low and START, STOP and address bytes are ignored. Afterwards the pointer is 0x00.
- R10: A read at a pointer of 24 or above returns 0x00 with no read strobe, and the pointer keeps advancing.
- R11: After the synchronous reset, `sda_oe`, `reg_wr_en`, `reg_rd_en` and `rst_req` are low and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | High pulls SDA low |
| reg_addr | output | 8 | Current pointer, register file address |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Write data |
| reg_rd_en | output | 1 | One-cycle strobe when a byte is taken for transmission |
| reg_rd_data | input | 8 | Register file content at `reg_addr` |
| rst_req | output | 1 | Register-file reset request, high for the busy window |

## Verification
The bench keeps the default 24 locations, the 9..18 writable window and a glitch filter of three clocks. Each SCL phase lasts twelve system clocks, well beyond the seven-clock path through synchronizer, filter and edge decode, so ACK timing and next-bit presentation are both exercised at the filtered edges. RST_CLKS is raised to 600 so that a complete START plus address byte fits inside the reset window, which makes the "bus ignored while busy" case observable at the pins. Reads that start near the top of the map run past location 23 and cover the forced-zero path.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_WDATA, ST_GCMD, ST_TX, ST_RST
  } port_st_e;

  localparam logic [7:0] GC_RESET_CMD = 8'h06;
  localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
  end

  // output follows only after the synced level differs for FILT_LEN clocks
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= 1'b1;
      cnt  <= '0;
    end else if (sync_q[SYNC_STAGES-1] == dout) begin
      cnt <= '0;
    end else if (cnt == CW'(FILT_LEN - 1)) begin
      dout <= sync_q[SYNC_STAGES-1];
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_regport_fsm.sv
module i2c_regport_fsm
  import i2c_regport_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter int NUM_REGS  = 24,
  parameter int WR_LO     = 9,
  parameter int WR_HI     = 18,
  parameter logic [7:0] RST_PTR = 8'hBF,
  parameter int RST_CLKS  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_lvl,
  input  logic       sda_f,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic [7:0] ptr,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       rd_en,
  output logic       rst_req
);
  localparam int         BCW    = $clog2(RST_CLKS + 1);
  localparam logic [7:0] NREG_B = 8'(NUM_REGS);
  localparam logic [7:0] WLO_B  = 8'(WR_LO);
  localparam logic [7:0] WHI_B  = 8'(WR_HI);
  localparam logic [7:0] ADR_W  = {DEV_ADDR, 1'b0};
  localparam logic [7:0] ADR_R  = {DEV_ADDR, 1'b1};

  port_st_e       state, nxt;
  logic           ack_ph;
  logic [3:0]     bitcnt;
  logic [7:0]     shreg;
  logic [BCW-1:0] busy_cnt;

  logic       in_range, writable;
  logic [7:0] tx_byte;
  assign in_range = (ptr < NREG_B);
  assign writable = (ptr >= WLO_B) && (ptr <= WHI_B);
  assign tx_byte  = in_range ? rd_data : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;  nxt <= ST_IDLE;  ack_ph <= 1'b0;
      bitcnt <= '0;      shreg <= '0;     sda_oe <= 1'b0;
      ptr <= '0;         wr_en <= 1'b0;   wr_data <= '0;
      rd_en <= 1'b0;     rst_req <= 1'b0; busy_cnt <= '0;
    end else begin
      wr_en <= 1'b0;
      rd_en <= 1'b0;
      if (state == ST_RST) begin
        sda_oe <= 1'b0;
        if (busy_cnt == BCW'(RST_CLKS - 1)) begin
          state <= ST_IDLE; rst_req <= 1'b0; ptr <= '0; busy_cnt <= '0;
        end else begin
          busy_cnt <= busy_cnt + 1'b1;
        end
      end else if (stop_det) begin
        state <= ST_IDLE; ptr <= '0; sda_oe <= 1'b0; ack_ph <= 1'b0;
      end else if (start_det) begin
        state <= ST_ADDR; bitcnt <= '0; sda_oe <= 1'b0; ack_ph <= 1'b0;
      end else if (state == ST_IDLE) begin
        sda_oe <= 1'b0;
      end else if (ack_ph) begin
        if (scl_fall) begin
          ack_ph <= 1'b0; sda_oe <= 1'b0; bitcnt <= '0; state <= nxt;
          if (state == ST_WDATA) ptr <= ptr + 1'b1;
          if (nxt == ST_RST) begin rst_req <= 1'b1; busy_cnt <= '0; end
          if (nxt == ST_TX) begin
            shreg <= tx_byte; sda_oe <= ~tx_byte[7]; rd_en <= in_range;
          end
        end
      end else if (state == ST_TX) begin
        if (scl_rise) begin
          if (bitcnt == 4'd8) begin
            if (sda_f) state <= ST_IDLE;
            else begin ptr <= ptr + 1'b1; bitcnt <= 4'd9; end
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd9) begin
            bitcnt <= '0; shreg <= tx_byte; sda_oe <= ~tx_byte[7]; rd_en <= in_range;
          end else if (bitcnt == 4'd8) begin
            sda_oe <= 1'b0;
          end else if (bitcnt != 4'd0) begin
            shreg <= {shreg[6:0], 1'b0}; sda_oe <= ~shreg[6];
          end
        end
      end else begin
        if (scl_rise && bitcnt != 4'd8) begin
          shreg <= {shreg[6:0], sda_f}; bitcnt <= bitcnt + 1'b1;
        end else if (scl_fall && bitcnt == 4'd8) begin
          case (state)
            ST_ADDR: begin
              if (shreg == ADR_W)             begin ack_ph <= 1'b1; sda_oe <= 1'b1; nxt <= ST_PTR;  end
              else if (shreg == ADR_R)        begin ack_ph <= 1'b1; sda_oe <= 1'b1; nxt <= ST_TX;   end
              else if (shreg == GC_ADDR_BYTE) begin ack_ph <= 1'b1; sda_oe <= 1'b1; nxt <= ST_GCMD; end
              else state <= ST_IDLE;
            end
            ST_PTR: begin
              if (shreg == RST_PTR) begin
                state <= ST_RST; rst_req <= 1'b1; busy_cnt <= '0;
              end else begin
                ptr <= shreg; ack_ph <= 1'b1; sda_oe <= 1'b1; nxt <= ST_WDATA;
              end
            end
            ST_WDATA: begin
              ack_ph <= 1'b1; sda_oe <= 1'b1; nxt <= ST_WDATA;
              if (writable) begin wr_en <= 1'b1; wr_data <= shreg; end
            end
            ST_GCMD: begin
              if (shreg == GC_RESET_CMD) begin ack_ph <= 1'b1; sda_oe <= 1'b1; nxt <= ST_RST; end
              else state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // R1: the data line is only ever taken low while the filtered clock is low
  p_drive_on_low_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_lvl);
  // R4: a STOP outside the reset window clears the pointer
  p_stop_clears_ptr_r4: assert property (@(posedge clk) disable iff (rst)
    (stop_det && state != ST_RST) |=> (ptr == 8'h00));
  // R5: write strobes only inside the writable window
  p_wr_window_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (ptr >= WLO_B && ptr <= WHI_B));
  // R9: the bus is never driven during a reset
  p_quiet_in_reset_r9: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !sda_oe);
  // R10: no read strobe for locations past the map
  p_rd_in_map_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (ptr < NREG_B));
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter int NUM_REGS    = 24,
  parameter int WR_LO       = 9,
  parameter int WR_HI       = 18,
  parameter logic [7:0] RST_PTR = 8'hBF,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int RST_CLKS    = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic       reg_wr_en,
  output logic [7:0] reg_wr_data,
  output logic       reg_rd_en,
  input  logic [7:0] reg_rd_data,
  output logic       rst_req
);
  logic [1:0] raw, filt;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst(rst), .din(raw[g]), .dout(filt[g]));
  end

  i2c_bus_events u_ev (
    .clk(clk), .rst(rst), .scl_f(filt[0]), .sda_f(filt[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  i2c_regport_fsm #(
    .DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .WR_LO(WR_LO), .WR_HI(WR_HI),
    .RST_PTR(RST_PTR), .RST_CLKS(RST_CLKS)
  ) u_fsm (
    .clk(clk), .rst(rst), .scl_lvl(filt[0]), .sda_f(filt[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(reg_rd_data), .sda_oe(sda_oe), .ptr(reg_addr),
    .wr_en(reg_wr_en), .wr_data(reg_wr_data), .rd_en(reg_rd_en),
    .rst_req(rst_req));
endmodule

// File: tb/i2c_regport_test.sv
module i2c_regport_test;
  localparam int W    = 12;
  localparam int NREG = 24;
  localparam int RCLK = 600;

  logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_wr_en, reg_rd_en, rst_req, rreq_q;
  logic [7:0] reg_addr, reg_wr_data, reg_rd_data;
  logic [7:0] rf [NREG];
  logic [7:0] exp_mem [NREG];
  int n_chk = 0, n_bad = 0, rd_cnt = 0, rq_len = 0, quiet_viol = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wire sda_bus = sda_m & ~sda_oe;

  i2c_regport #(.RST_CLKS(RCLK)) uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data), .rst_req(rst_req));

  function automatic logic [7:0] def_val(int i);
    return 8'(i * 29 + 7);
  endfunction
  function automatic bit writable(int a);
    return (a >= 9) && (a <= 18);
  endfunction
  function automatic logic [7:0] exp_rd(int a);
    return (a < NREG) ? exp_mem[a] : 8'h00;
  endfunction

  assign reg_rd_data = (reg_addr < 8'(NREG)) ? rf[reg_addr[4:0]] : 8'hA5;

  always @(posedge clk) begin
    rreq_q <= rst_req;
    if (rst || (rst_req && !rreq_q)) begin
      for (int i = 0; i < NREG; i++) rf[i] <= def_val(i);
    end else if (reg_wr_en && reg_addr < 8'(NREG)) begin
      rf[reg_addr[4:0]] <= reg_wr_data;
    end
    if (reg_rd_en) rd_cnt <= rd_cnt + 1;
    if (rst_req) rq_len <= rq_len + 1;
  end

  always @(negedge clk) if (rst_req && sda_oe) quiet_viol <= quiet_viol + 1;

  task automatic chk(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; tick(W); scl_m = 1'b1; tick(W);
    sda_m = 1'b0; tick(W); scl_m = 1'b0; tick(4);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(W); scl_m = 1'b1; tick(W); sda_m = 1'b1; tick(W);
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(W); scl_m = 1'b1; tick(W); scl_m = 1'b0; tick(4);
    end
    sda_m = 1'b1; tick(W); scl_m = 1'b1; tick(W / 2);
    ack = sda_oe;
    tick(W / 2); scl_m = 1'b0; tick(4);
  endtask

  task automatic recv(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(W); scl_m = 1'b1; tick(W / 2);
      b[i] = ~sda_oe;
      tick(W / 2); scl_m = 1'b0; tick(4);
    end
    sda_m = mack ? 1'b0 : 1'b1;
    tick(W); scl_m = 1'b1; tick(W); scl_m = 1'b0; tick(4);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] p, input int n, input string tag);
    bit a, all_ack;
    logic [7:0] d;
    all_ack = 1;
    bstart(); send(8'h90, a); all_ack &= a; send(p, a); all_ack &= a;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send(d, a); all_ack &= a;
      if (writable(int'(p) + k)) exp_mem[int'(p) + k] = d;
    end
    bstop();
    chk({tag, " write acks"}, all_ack, 1);
  endtask

  task automatic do_read(input logic [7:0] p, input int n, input bit set_ptr, input string tag);
    bit a;
    logic [7:0] b;
    bstart();
    if (set_ptr) begin send(8'h90, a); send(p, a); bstart(); end
    send(8'h91, a);
    chk({tag, " read addr ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      recv(k != n - 1, b);
      chk({tag, " read data"}, b, exp_rd(int'(p) + k));
    end
    bstop();
  endtask

  initial begin
    bit a;
    logic [7:0] b, b2;
    int base;
    void'($urandom(32'd2718));
    for (int i = 0; i < NREG; i++) exp_mem[i] = def_val(i);
    tick(5);
    // R11: idle outputs after reset
    chk("R11 sda_oe", sda_oe, 0);
    chk("R11 wr/rd/rst", {reg_wr_en, reg_rd_en, rst_req}, 0);
    chk("R11 pointer", reg_addr, 0);
    rst = 1'b0; tick(5);

    // R1: address matching
    bstart(); send(8'hA0, a); bstop(); chk("R1 foreign addr nack", a, 0);
    bstart(); send(8'h92, a); bstop(); chk("R1 near addr nack", a, 0);
    bstart(); send(8'h90, a); bstop(); chk("R1 own addr ack", a, 1);

    // R2: burst write then read back
    do_write(8'h09, 3, "R2");
    do_read(8'h09, 3, 1, "R2");

    // R5: read-only and out-of-map writes acked but discarded
    do_write(8'h02, 2, "R5");
    do_write(8'h14, 2, "R5");
    do_read(8'h02, 2, 1, "R5");

    // R4: pointer back at 0 after STOP
    do_read(8'h00, 2, 0, "R4");

    // R6: pointer load then repeated START read
    do_write(8'h0C, 2, "R6");
    do_read(8'h0C, 2, 1, "R6");

    // R3: NACK leaves the pointer in place
    bstart(); send(8'h90, a); send(8'h0A, a);
    bstart(); send(8'h91, a); recv(0, b);
    bstart(); send(8'h91, a); recv(0, b2); bstop();
    chk("R3 nack first", b, exp_rd(10));
    chk("R3 nack no increment", b2, exp_rd(10));

    // R10: reads past the map
    base = rd_cnt;
    do_read(8'h16, 4, 1, "R10");
    chk("R10 read strobes", rd_cnt - base, 2);

    // R7: general call reset and rejected command
    do_write(8'h09, 1, "R7");
    bstart(); send(8'h00, a); chk("R7 gc addr ack", a, 1);
    send(8'h07, a); bstop(); chk("R7 gc other nack", a, 0);
    do_read(8'h09, 1, 1, "R7 not reset");
    rq_len = 0;
    bstart(); send(8'h00, a); send(8'h06, a); chk("R7 gc reset ack", a, 1);
    bstop(); tick(RCLK + 10);
    for (int i = 0; i < NREG; i++) exp_mem[i] = def_val(i);
    chk("R9 window length gc", rq_len, RCLK);
    do_read(8'h09, 2, 1, "R7 defaults");

    // R8 / R9: reset pointer, bus ignored while busy
    do_write(8'h0B, 1, "R8");
    rq_len = 0;
    bstart(); send(8'h90, a); send(8'hBF, a); chk("R8 reset ptr nack", a, 0);
    bstart(); send(8'h90, a); chk("R9 busy addr ignored", a, 0);
    bstop(); tick(RCLK);
    for (int i = 0; i < NREG; i++) exp_mem[i] = def_val(i);
    chk("R9 window length ptr", rq_len, RCLK);
    do_read(8'h00, 1, 0, "R9 pointer zero");
    do_read(8'h0B, 1, 1, "R8 defaults");

    // R2/R3/R5/R10: constrained random traffic
    for (int it = 0; it < 40; it++) begin
      if ($urandom % 2 == 0) do_write(8'($urandom % 28), 1 + int'($urandom % 4), "R2 rnd");
      else do_read(8'($urandom % 26), 1 + int'($urandom % 4), 1, "R3 rnd");
    end

    chk("R9 no drive in reset", quiet_viol, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule